// File: doc/BRIEF.md
# Sequential RC5-32 Key Schedule Engine

This block turns one candidate secret key into the expanded RC5 round-key table for 32-bit words. It does one mixing step per clock with a single mixing element. The rounds and key length are fixed by parameters at elaboration, so the table length is T = 2·ROUNDS + 2 words and the key occupies C = ceil(KEY_BYTES/4) words. An exhaustive key-search engine would pulse `start_i` with a candidate key and wait for `done_o`. It would then read the whole table in index order and pass it to a decryption stage.

Both the table and the key-word array are word-wide rotating shift registers. The mixing element always reads the head word of each. Its result enters at the tail, and the rest of the array moves one place toward index 0. The key pass runs 3·max(T, C) steps. If that count is not a multiple of T, the engine adds a few pure rotation cycles afterwards, so that S[0] is back at the head before completion is signalled.

Top module: `rc5_key_sched`

## Requirements
- R1: While reset is asserted, and after its release until a start is accepted, `done_o` is low.
- R2: In the cycle after a start is accepted, `s_table_o` holds the seeded table: word 0 is 0xB7E15163, and each later word is the previous one plus 0x9E3779B9 modulo 2^32. Word i sits at bits [32i+31:32i].
- R3: Key byte k is `key_i[8k+7:8k]`. Key word j takes bytes 4j..4j+3, with byte 4j in its least significant byte. Bytes past KEY_BYTES read as zero.
- R4: Each step starts from A and B, which are cleared to zero at start. It sets A to (S_i + A + B) rotated left by 3 and writes A into S_i. It then sets B to (L_j + A + B) rotated left by the low 5 bits of (A + B) and writes B into L_j. The indices i and j advance modulo T and modulo C. A rotation amount of 0 leaves the word unchanged.
- R5: `done_o` rises exactly 3·max(T, C) + ((T − (3·max(T, C) mod T)) mod T) clock edges after the edge that accepted the start.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: When `done_o` is high, `s_table_o` holds the finished table in index order. It keeps that value until the next accepted start.
- R8: A start pulse that arrives while a computation is in progress is ignored. The running key keeps going, and completion timing is unchanged.
- R9: Asserting reset during a computation aborts it. No `done_o` follows until a new start is accepted.
- R10: When the step count is not a multiple of T, the extra rotation cycles still return the table in index order (S[0] in the lowest word).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin expansion of `key_i` when idle |
| key_i | input | 8·KEY_BYTES | Candidate key, byte k at bits [8k+7:8k] |
| done_o | output | 1 | One-cycle completion pulse |
| s_table_o | output | 32·T | Expanded table, word i at bits [32i+31:32i] |

## Verification
The bench builds two instances. The default build (12 rounds, 9-byte key) has T = 26 and C = 3. Its 78 steps are a multiple of T, so no rotation tail is needed, and its partially filled third key word exercises the zero padding. The second build (1 round, 18-byte key) has T = 4 and C = 5. There the key array is longer than the table, and 15 steps leave the table one place out of order. That brings the alignment tail of R10 and the wrap of the table index within reach. Both builds also face restarts while busy, a start held high across completion, and reset in the middle of a run.

// File: rtl/rc5ks_pkg.sv
package rc5ks_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned ROT_W  = 5;

  localparam logic [WORD_W-1:0] SEED_WORD = 32'hB7E15163;
  localparam logic [WORD_W-1:0] STEP_WORD = 32'h9E3779B9;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_MIX   = 2'd1,
    KS_ALIGN = 2'd2
  } ks_state_e;

  // Left rotation; an amount of zero returns the word unchanged.
  function automatic logic [WORD_W-1:0] rotl_word(input logic [WORD_W-1:0] x,
                                                  input logic [ROT_W-1:0]  n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

endpackage

// File: rtl/rc5ks_ring.sv
module rc5ks_ring #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [WIDTH*DEPTH-1:0] load_vec_i,
  input  logic                   shift_i,
  input  logic [WIDTH-1:0]       tail_i,
  output logic [WIDTH-1:0]       head_o,
  output logic [WIDTH*DEPTH-1:0] vec_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] mem_d [DEPTH];
  logic             mem_en;

  assign mem_en = load_i | shift_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    if (k == DEPTH - 1) begin : g_tail
      always_comb begin
        if (load_i) mem_d[k] = load_vec_i[WIDTH*k +: WIDTH];
        else        mem_d[k] = tail_i;
      end
    end else begin : g_body
      always_comb begin
        if (load_i) mem_d[k] = load_vec_i[WIDTH*k +: WIDTH];
        else        mem_d[k] = mem_q[k+1];
      end
    end

    always_ff @(posedge clk_i) begin
      if (mem_en) mem_q[k] <= mem_d[k];
    end

    assign vec_o[WIDTH*k +: WIDTH] = mem_q[k];
  end

  assign head_o = mem_q[0];

  // R7
  ring_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(vec_o));

  if (DEPTH > 1) begin : g_adv_chk
    // R4
    ring_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i) |=> (head_o == $past(vec_o[2*WIDTH-1:WIDTH])));
  end

endmodule

// File: rtl/rc5ks_mix.sv
module rc5ks_mix
  import rc5ks_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] s_head_i,
  input  logic [WORD_W-1:0] l_head_i,
  output logic [WORD_W-1:0] s_new_o,
  output logic [WORD_W-1:0] l_new_o
);

  logic [WORD_W-1:0] a_q, b_q, a_d, b_d;
  logic [WORD_W-1:0] ab_sum;
  logic              ab_en;

  always_comb begin
    s_new_o = rotl_word(s_head_i + a_q + b_q, ROT_W'(3));
    ab_sum  = s_new_o + b_q;
    l_new_o = rotl_word(l_head_i + ab_sum, ab_sum[ROT_W-1:0]);
  end

  assign ab_en = clear_i | step_i;

  always_comb begin
    if (clear_i) begin
      a_d = '0;
      b_d = '0;
    end else begin
      a_d = s_new_o;
      b_d = l_new_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ab_en) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // R4
  ab_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (a_q == '0 && b_q == '0));

  // R4
  clear_step_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_i && step_i));

endmodule

// File: rtl/rc5ks_ctrl.sv
module rc5ks_ctrl
  import rc5ks_pkg::*;
#(
  parameter int unsigned STEPS = 78,
  parameter int unsigned ALIGN = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic mix_o,
  output logic align_o,
  output logic done_o
);

  localparam int unsigned CW         = $clog2(STEPS + 1);
  localparam int unsigned ALIGN_LAST = (ALIGN > 0) ? ALIGN - 1 : 0;

  ks_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    load_o  = (state_q == KS_IDLE) && start_i;
    mix_o   = (state_q == KS_MIX);
    align_o = (state_q == KS_ALIGN);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      KS_IDLE: begin
        if (start_i) begin
          state_d = KS_MIX;
          cnt_d   = '0;
        end
      end
      KS_MIX: begin
        if (cnt_q == CW'(STEPS - 1)) begin
          cnt_d = '0;
          if (ALIGN > 0) begin
            state_d = KS_ALIGN;
          end else begin
            state_d = KS_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      KS_ALIGN: begin
        if (cnt_q == CW'(ALIGN_LAST)) begin
          cnt_d   = '0;
          state_d = KS_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = KS_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KS_MIX) |-> (cnt_q < CW'(STEPS)));

  // R8
  cnt_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KS_MIX && $past(state_q) == KS_MIX) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R8
  phase_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, mix_o, align_o}));

endmodule

// File: rtl/rc5_key_sched.sv
module rc5_key_sched
  import rc5ks_pkg::*;
#(
  parameter int unsigned ROUNDS    = 12,
  parameter int unsigned KEY_BYTES = 9
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                start_i,
  input  logic [8*KEY_BYTES-1:0]              key_i,
  output logic                                done_o,
  output logic [WORD_W*(2*ROUNDS+2)-1:0]      s_table_o
);

  localparam int unsigned T_WORDS = 2 * ROUNDS + 2;
  localparam int unsigned C_WORDS = (KEY_BYTES + 3) / 4;
  localparam int unsigned PASS_W  = (T_WORDS > C_WORDS) ? T_WORDS : C_WORDS;
  localparam int unsigned STEPS   = 3 * PASS_W;
  localparam int unsigned ALIGN   = (T_WORDS - (STEPS % T_WORDS)) % T_WORDS;

  logic                          load_en, mix_en, align_en;
  logic [WORD_W*T_WORDS-1:0]     s_seed;
  logic [WORD_W*C_WORDS-1:0]     l_seed;
  logic [WORD_W-1:0]             s_head, l_head, s_new, l_new, s_tail;
  logic                          s_shift;
  logic [WORD_W*C_WORDS-1:0]     l_vec;

  // Seeded table: arithmetic progression from the two constants.
  for (genvar i = 0; i < T_WORDS; i++) begin : g_seed
    assign s_seed[WORD_W*i +: WORD_W] = SEED_WORD + WORD_W'(i) * STEP_WORD;
  end

  // Key words, little-endian byte packing with zero fill.
  for (genvar j = 0; j < C_WORDS; j++) begin : g_lword
    for (genvar m = 0; m < 4; m++) begin : g_lbyte
      if (4 * j + m < KEY_BYTES) begin : g_used
        assign l_seed[WORD_W*j + 8*m +: 8] = key_i[8*(4*j+m) +: 8];
      end else begin : g_pad
        assign l_seed[WORD_W*j + 8*m +: 8] = 8'h00;
      end
    end
  end

  rc5ks_ctrl #(
    .STEPS (STEPS),
    .ALIGN (ALIGN)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load_en),
    .mix_o   (mix_en),
    .align_o (align_en),
    .done_o  (done_o)
  );

  rc5ks_mix u_mix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (load_en),
    .step_i   (mix_en),
    .s_head_i (s_head),
    .l_head_i (l_head),
    .s_new_o  (s_new),
    .l_new_o  (l_new)
  );

  assign s_shift = mix_en | align_en;
  assign s_tail  = mix_en ? s_new : s_head;

  rc5ks_ring #(
    .WIDTH (WORD_W),
    .DEPTH (T_WORDS)
  ) u_s_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_en),
    .load_vec_i (s_seed),
    .shift_i    (s_shift),
    .tail_i     (s_tail),
    .head_o     (s_head),
    .vec_o      (s_table_o)
  );

  rc5ks_ring #(
    .WIDTH (WORD_W),
    .DEPTH (C_WORDS)
  ) u_l_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_en),
    .load_vec_i (l_seed),
    .shift_i    (mix_en),
    .tail_i     (l_new),
    .head_o     (l_head),
    .vec_o      (l_vec)
  );

  // R7
  table_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(s_table_o));

  // R2
  seed_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> (s_head == SEED_WORD));

  // R3
  key_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> (l_vec == $past(l_seed)));

endmodule

// File: tb/ks_harness.sv
module ks_harness #(
  parameter int ROUNDS = 12,
  parameter int KB     = 9
) (
  input  logic clk,
  output int   n_chk,
  output int   n_fail,
  output bit   fin
);

  localparam int T     = 2 * ROUNDS + 2;
  localparam int C     = (KB + 3) / 4;
  localparam int NSTEP = 3 * ((T > C) ? T : C);
  localparam int TOTAL = NSTEP + ((T - (NSTEP % T)) % T);

  logic              rst_n;
  logic              start;
  logic [8*KB-1:0]   key;
  logic              done;
  logic [32*T-1:0]   tab;

  rc5_key_sched #(.ROUNDS(ROUNDS), .KEY_BYTES(KB)) i_rc5_key_sched (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .key_i     (key),
    .done_o    (done),
    .s_table_o (tab)
  );

  function automatic int unsigned rl(input int unsigned x, input int unsigned n);
    int unsigned s;
    s = n % 32;
    if (s == 0) return x;
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [32*T-1:0] seed_table();
    logic [32*T-1:0] v;
    int unsigned w;
    w = 32'hB7E15163;
    for (int i = 0; i < T; i++) begin
      v[32*i +: 32] = w;
      w = w + 32'h9E3779B9;
    end
    return v;
  endfunction

  function automatic logic [32*T-1:0] ref_table(input logic [8*KB-1:0] k);
    int unsigned s[T];
    int unsigned l[C];
    int unsigned a, b;
    int i, j;
    logic [32*T-1:0] v;
    for (int x = 0; x < C; x++) l[x] = 0;
    for (int x = 0; x < KB; x++) l[x/4] = l[x/4] | (int'(k[8*x +: 8]) << (8*(x%4)));
    s[0] = 32'hB7E15163;
    for (int x = 1; x < T; x++) s[x] = s[x-1] + 32'h9E3779B9;
    a = 0; b = 0; i = 0; j = 0;
    for (int n = 0; n < NSTEP; n++) begin
      a = rl(s[i] + a + b, 3);
      s[i] = a;
      b = rl(l[j] + a + b, a + b);
      l[j] = b;
      i = (i + 1) % T;
      j = (j + 1) % C;
    end
    for (int x = 0; x < T; x++) v[32*x +: 32] = s[x];
    return v;
  endfunction

  // Behavioural model of the cycle timing.
  int              remaining;
  bit              exp_done, show_seed, have_res;
  logic [32*T-1:0] exp_tab;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining = 0;
      exp_done  = 0;
      show_seed = 0;
      have_res  = 0;
    end else begin
      exp_done  = 0;
      show_seed = 0;
      if (remaining > 0) begin
        remaining = remaining - 1;
        if (remaining == 0) begin
          exp_done = 1;
          have_res = 1;
        end
      end else if (start) begin
        remaining = TOTAL;
        show_seed = 1;
        have_res  = 0;
        exp_tab   = ref_table(key);
      end
    end
  end

  bit checking;

  always @(negedge clk) begin
    if (checking) begin
      n_chk = n_chk + 1;
      if (done !== exp_done) begin
        n_fail = n_fail + 1;
        $display("FAIL R1/R5/R6/R8/R9 done (T=%0d): actual %0b expected %0b at %0t",
                 T, done, exp_done, $time);
      end
      if (show_seed) begin
        n_chk = n_chk + 1;
        if (tab !== seed_table()) begin
          n_fail = n_fail + 1;
          $display("FAIL R2 seed table (T=%0d): actual %h expected %h", T, tab, seed_table());
        end
      end
      if (have_res && remaining == 0) begin
        n_chk = n_chk + 1;
        if (tab !== exp_tab) begin
          n_fail = n_fail + 1;
          $display("FAIL R3/R4/R7/R10 table (T=%0d): actual %h expected %h", T, tab, exp_tab);
        end
      end
    end
  end

  task automatic run_key(input logic [8*KB-1:0] k);
    @(negedge clk);
    key   = k;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (TOTAL + 3) @(negedge clk);
  endtask

  function automatic logic [8*KB-1:0] rand_key();
    logic [8*KB-1:0] v;
    for (int x = 0; x < KB; x++) v[8*x +: 8] = 8'($urandom);
    return v;
  endfunction

  initial begin
    logic [8*KB-1:0] kv;
    n_chk = 0; n_fail = 0; fin = 0; checking = 0;
    start = 0; key = '0; rst_n = 0;
    @(negedge clk);
    checking = 1;
    // R1: reset held, then released with no start.
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R3 R4: distinct key patterns.
    run_key('0);
    run_key('1);
    for (int x = 0; x < KB; x++) kv[8*x +: 8] = 8'(x + 1);
    run_key(kv);
    for (int x = 0; x < KB; x++) kv[8*x +: 8] = (x == KB - 1) ? 8'h80 : 8'h00;
    run_key(kv);
    for (int n = 0; n < 3; n++) run_key(rand_key());
    // R8: extra start pulses while busy.
    @(negedge clk);
    key = rand_key(); start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    key = rand_key(); start = 1;
    @(negedge clk);
    start = 0;
    repeat (TOTAL - 5) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    // R6 R8: start held high across several completions.
    key = rand_key(); start = 1;
    repeat (2 * TOTAL + 5) @(negedge clk);
    start = 0;
    repeat (TOTAL + 3) @(negedge clk);
    // R9: reset in mid-run.
    key = rand_key(); start = 1;
    @(negedge clk);
    start = 0;
    repeat (TOTAL / 2) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (TOTAL + 4) @(negedge clk);
    run_key(rand_key());
    checking = 0;
    fin = 1;
  end

endmodule

// File: tb/test_rc5_key_sched.sv
module test_rc5_key_sched;

  logic clk;
  int   chk0, fail0, chk1, fail1;
  bit   fin0, fin1;
  int   wd_fail;

  initial clk = 0;
  always #5 clk = ~clk;

  // Default build: T=26, C=3, no alignment tail.
  ks_harness #(.ROUNDS(12), .KB(9)) u_def (
    .clk(clk), .n_chk(chk0), .n_fail(fail0), .fin(fin0));

  // Short table, long key: T=4, C=5, one alignment cycle (R10).
  ks_harness #(.ROUNDS(1), .KB(18)) u_alt (
    .clk(clk), .n_chk(chk1), .n_fail(fail1), .fin(fin1));

  initial begin
    int cyc;
    cyc = 0;
    wd_fail = 0;
    while (!(fin0 && fin1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(fin0 && fin1)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             chk0 + chk1 + wd_fail, fail0 + fail1 + wd_fail);
    $finish;
  end

endmodule